// File: doc/BRIEF.md
# Decision-Directed Carrier Removal Loop

This block strips residual carrier frequency and phase from a stream of complex baseband samples. Each accepted 12-bit signed I/Q sample is rotated by a locally generated 12-bit cosine/sine pair taken from a 32-bit phase accumulator. The rotated (mixed) sample leaves the block on an output stream and also feeds a phase detector.

The phase detector is a programmable 4096-entry, 1-bit table indexed by the coarse quantised mixed I and Q. Its single bit says whether the constellation point sits ahead of or behind its decision region. A proportional-plus-integral loop filter with power-of-two gains turns that bit into frequency and phase corrections for the accumulator. Software fills the table with the decision map of the modulation in use while the loop is frozen.

Both data interfaces are valid/ready. An output beat is held, with stable data, until it is taken. The four-stage pipeline moves as a single unit: it stalls whenever its last stage is full and not being taken. The input can therefore be ready only when the output is empty or is being taken in the same cycle, and never while the loop is frozen.

Top module: `cr_carrier_loop`

## Requirements
- R1: While out_valid is 1 and out_ready is 0, out_valid, out_i and out_q keep their values at the next edge. in_ready equals (not freeze) and ((not out_valid) or out_ready).
- R2: With out_ready held at 1, a sample accepted at one clock edge shows on out_valid, with its result, four clock cycles after that acceptance.
- R3: A sample uses t = phase[31:20] as the accumulator stands in its acceptance cycle. For a 12-bit angle a, h(a) = min(2047, (x*(2048-x)) >> 9) with x = a[10:0], negated when a[11] is 1. Sine is h(t) and cosine is h(t+1024 mod 4096).
- R4: out_i = sat((I*cos + Q*sin + 1024) >>> 11) and out_q = sat((Q*cos - I*sin + 1024) >>> 11). Here >>> is an arithmetic (floor) shift and sat clamps to [-2048, 2047].
- R5: The table address is {out_i[11:6], out_q[11:6]}, with out_i in the upper six bits. A stored 1 acts as an error of +1 and a stored 0 as an error of -1.
- R6: On a loop update with error e, the integrator becomes integ + e*2^ki_shift, and phase becomes phase + freq_word + (new integ) + e*2^kp_shift, all modulo 2^32. A shift value of 32 or more makes its term zero. The phase port shows the accumulator.
- R7: The loop updates at exactly those edges where an output beat is taken (out_valid and out_ready) and freeze is 0; at any other edge phase does not change.
- R8: While freeze is 1, in_ready is 0. A table write (lut_wr_en) takes effect only at an edge where freeze is 1; writes made with freeze at 0 are ignored.
- R9: After reset, phase and the integrator are 0 and out_valid is 0. Table contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes the input sample this cycle |
| in_i | input | 12 | Input in-phase sample, signed |
| in_q | input | 12 | Input quadrature sample, signed |
| out_valid | output | 1 | Mixed sample present |
| out_ready | input | 1 | Downstream takes the mixed sample |
| out_i | output | 12 | Mixed in-phase sample, signed |
| out_q | output | 12 | Mixed quadrature sample, signed |
| freq_word | input | 32 | Nominal phase increment per loop update |
| kp_shift | input | 6 | Proportional gain as a power of two |
| ki_shift | input | 6 | Integral gain as a power of two |
| freeze | input | 1 | Hold the loop, block input, allow table writes |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_addr | input | 12 | Table write address |
| lut_wr_data | input | 1 | Table write bit |
| phase | output | 32 | Current phase accumulator |

## Verification
The bench drives full-scale inputs (+2047 and -2048 on both rails) at angles near 45 degrees. A mixer without clamping would wrap a product of magnitude about 2900 into a wrong-signed output, and wrong rounding would be off by one at the half-LSB points. Random back-pressure probes the rigid stall: a pipeline that advanced while its output was held would drop or duplicate beats, and a loop that updated on stalled beats would drift its phase. Table writes issued while the loop runs, and freeze windows during live traffic, expose a write path that ignores freeze or a loop that keeps updating while frozen. Both show up as a divergence of the phase port from the model. Gains of 32 and above, and accumulator wrap, check that the loop arithmetic is modulo 2^32 and that large shifts give a zero term.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int CR_DW = 12;  // sample width
  localparam int CR_PW = 32;  // phase accumulator width
  localparam int CR_TW = 12;  // angle bits fed to the oscillator
  localparam int CR_AB = 6;   // quantiser bits per rail for the table
  localparam int CR_GW = 6;   // gain shift width

  typedef enum logic {
    ERR_BEHIND = 1'b0,
    ERR_AHEAD  = 1'b1
  } err_dir_e;
endpackage

// File: rtl/cr_trig.sv
module cr_trig #(
  parameter int TW = 12,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [TW-1:0]        t,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int XW   = TW - 1;
  localparam int MW   = 2 * XW + 1;
  localparam int SH   = 2 * XW - (DW + 1);
  localparam int HALF = 1 << XW;
  localparam int AMP  = (1 << (DW - 1)) - 1;
  localparam logic [TW-1:0] QUARTER = TW'(1 << (TW - 2));

  // Parabolic half-wave: x*(HALF-x) scaled to full amplitude, sign from MSB
  function automatic logic signed [DW-1:0] half_wave(input logic [TW-1:0] a);
    logic [MW-1:0] xv;
    logic [MW-1:0] prod;
    logic [MW-1:0] mag;
    logic [DW-1:0] m;
    xv   = {{(MW-XW){1'b0}}, a[XW-1:0]};
    prod = xv * (MW'(HALF) - xv);
    mag  = prod >> SH;
    if (mag > MW'(AMP)) m = DW'(AMP);
    else                m = mag[DW-1:0];
    return a[TW-1] ? -$signed(m) : $signed(m);
  endfunction

  logic [TW-1:0] t_cos;
  assign t_cos = t + QUARTER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
    end else if (en) begin
      sin_o <= half_wave(t);
      cos_o <= half_wave(t_cos);
    end
  end

  // R3: the clamped waveform never reaches the most negative code
  p_trig_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_o != {1'b1, {(DW-1){1'b0}}}) && (cos_o != {1'b1, {(DW-1){1'b0}}}));
endmodule

// File: rtl/cr_cmix.sv
module cr_cmix #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] i,
  input  logic signed [DW-1:0] q,
  input  logic signed [DW-1:0] c,
  input  logic signed [DW-1:0] s,
  output logic signed [DW-1:0] y_i,
  output logic signed [DW-1:0] y_q
);
  localparam int MW = 2 * DW;
  localparam int SW = 2 * DW + 1;
  localparam logic signed [SW-1:0] HI  = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] LO  = -HI - SW'(1);
  localparam logic signed [SW-1:0] RND = SW'(1 << (DW - 2));

  logic signed [MW-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [SW-1:0] sum_i, sum_q, rnd_i, rnd_q;

  function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  // stage A: four partial products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ic <= '0;
      p_qs <= '0;
      p_qc <= '0;
      p_is <= '0;
    end else if (en) begin
      p_ic <= MW'(i) * MW'(c);
      p_qs <= MW'(q) * MW'(s);
      p_qc <= MW'(q) * MW'(c);
      p_is <= MW'(i) * MW'(s);
    end
  end

  // rotate by the conjugate of the oscillator, round half up, clamp
  always_comb begin
    sum_i = SW'(p_ic) + SW'(p_qs);
    sum_q = SW'(p_qc) - SW'(p_is);
    rnd_i = (sum_i + RND) >>> (DW - 1);
    rnd_q = (sum_q + RND) >>> (DW - 1);
  end

  // stage B: rounded, saturated result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_i <= '0;
      y_q <= '0;
    end else if (en) begin
      y_i <= clamp(rnd_i);
      y_q <= clamp(rnd_q);
    end
  end

  // R1: a stalled pipeline keeps its result
  p_mix_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_i) && $stable(y_q));
endmodule

// File: rtl/cr_err_lut.sv
module cr_err_lut #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int DEPTH = 1 << AW;

  logic mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rbit = mem[raddr];

  // R8: a gated write lands at its address
  p_lut_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/cr_loop.sv
module cr_loop
  import cr_pkg::*;
#(
  parameter int PW = 32,
  parameter int GW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  err_dir_e      err,
  input  logic [PW-1:0] freq,
  input  logic [GW-1:0] kp_sh,
  input  logic [GW-1:0] ki_sh,
  output logic [PW-1:0] phase_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] integ_q, phase_q;
  logic [PW-1:0] kp_mag, ki_mag, kp_term, ki_term, integ_nx;

  always_comb begin
    kp_mag   = ONE << kp_sh;   // shift of PW or more yields zero
    ki_mag   = ONE << ki_sh;
    kp_term  = (err == ERR_AHEAD) ? kp_mag : (PW'(0) - kp_mag);
    ki_term  = (err == ERR_AHEAD) ? ki_mag : (PW'(0) - ki_mag);
    integ_nx = integ_q + ki_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      phase_q <= '0;
    end else if (upd) begin
      integ_q <= integ_nx;
      phase_q <= phase_q + freq + integ_nx + kp_term;
    end
  end

  assign phase_o = phase_q;

  // R7: no loop step without an update strobe
  p_phase_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(phase_q));
  p_integ_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(integ_q));
endmodule

// File: rtl/cr_carrier_loop.sv
module cr_carrier_loop
  import cr_pkg::*;
#(
  parameter int DW = CR_DW,
  parameter int PW = CR_PW,
  parameter int TW = CR_TW,
  parameter int AB = CR_AB,
  parameter int GW = CR_GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  input  logic [PW-1:0] freq_word,
  input  logic [GW-1:0] kp_shift,
  input  logic [GW-1:0] ki_shift,
  input  logic          freeze,
  input  logic          lut_wr_en,
  input  logic [2*AB-1:0] lut_wr_addr,
  input  logic          lut_wr_data,
  output logic [PW-1:0] phase
);
  localparam int AW = 2 * AB;

  logic adv, acc, fire, upd, err_bit, lut_we;
  logic v1, v2, v3, v4;
  logic signed [DW-1:0] i1, q1, i2, q2, sin2, cos2, y_i, y_q;
  logic [TW-1:0] t1;
  logic [AW-1:0] lut_raddr;

  // rigid pipeline: every stage moves unless the last one is held
  assign adv      = !v4 || out_ready;
  assign in_ready = adv && !freeze;
  assign acc      = in_valid && in_ready;
  assign fire     = v4 && out_ready;
  assign upd      = fire && !freeze;
  assign lut_we   = lut_wr_en && freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
      i1 <= '0;   q1 <= '0;   i2 <= '0;   q2 <= '0;
      t1 <= '0;
    end else if (adv) begin
      v1 <= acc;
      i1 <= in_i;
      q1 <= in_q;
      t1 <= phase[PW-1 -: TW];
      v2 <= v1;
      i2 <= i1;
      q2 <= q1;
      v3 <= v2;
      v4 <= v3;
    end
  end

  cr_trig #(.TW(TW), .DW(DW)) u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .t     (t1),
    .sin_o (sin2),
    .cos_o (cos2)
  );

  cr_cmix #(.DW(DW)) u_mix (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .i     (i2),
    .q     (q2),
    .c     (cos2),
    .s     (sin2),
    .y_i   (y_i),
    .y_q   (y_q)
  );

  assign lut_raddr = {y_i[DW-1 -: AB], y_q[DW-1 -: AB]};

  cr_err_lut #(.AW(AW)) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lut_we),
    .waddr (lut_wr_addr),
    .wdata (lut_wr_data),
    .raddr (lut_raddr),
    .rbit  (err_bit)
  );

  cr_loop #(.PW(PW), .GW(GW)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .err     (err_dir_e'(err_bit)),
    .freq    (freq_word),
    .kp_sh   (kp_shift),
    .ki_sh   (ki_shift),
    .phase_o (phase)
  );

  assign out_valid = v4;
  assign out_i     = y_i;
  assign out_q     = y_q;

  // R1: held output beat stays put
  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));
  // R8: nothing enters while frozen
  p_frozen_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !in_ready);
  // R7: frozen loop keeps its phase
  p_frozen_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(phase));
endmodule

// File: tb/cr_carrier_loop_tb.sv
module cr_carrier_loop_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [11:0] in_i = '0, in_q = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [11:0] out_i, out_q;
  logic [31:0] freq_word = '0;
  logic [5:0]  kp_shift = 6'd63, ki_shift = 6'd63;
  logic        freeze = 1'b0;
  logic        lut_wr_en = 1'b0;
  logic [11:0] lut_wr_addr = '0;
  logic        lut_wr_data = 1'b0;
  logic [31:0] phase;

  cr_carrier_loop u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .freq_word(freq_word), .kp_shift(kp_shift),
    .ki_shift(ki_shift), .freeze(freeze), .lut_wr_en(lut_wr_en),
    .lut_wr_addr(lut_wr_addr), .lut_wr_data(lut_wr_data), .phase(phase)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit lut_ref [4096];
  logic [31:0] m_ph = '0, m_integ = '0;
  int cyc = 0, stall_cnt = 0;
  bit prev_hold = 1'b0;
  logic [11:0] prev_oi, prev_oq;
  bit done = 1'b0;

  typedef struct { int i; int q; int t; int acc_cyc; int mark; } item_t;
  item_t fifo[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3 model of the oscillator
  function automatic int wave(int a);
    int x, s;
    a = a & 4095;
    x = a & 2047;
    s = (x * (2048 - x)) >> 9;
    if (s > 2047) s = 2047;
    return (a >= 2048) ? -s : s;
  endfunction

  // R4 model of rounding and clamping
  function automatic int rsat(int v);
    int r;
    r = (v + 1024) >>> 11;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  // R6 model of a power-of-two term
  function automatic logic [31:0] term(bit e, logic [5:0] sh);
    logic [31:0] m;
    m = (sh >= 6'd32) ? 32'd0 : (32'd1 << sh);
    return e ? m : (32'd0 - m);
  endfunction

  task automatic monitor_step();
    bit exp_rdy;
    item_t it;
    int c, s, ei, eq, lat, adr;
    bit e;
    cyc++;
    chk(phase == m_ph, "R5/R6/R7", "phase", phase, m_ph);
    exp_rdy = !freeze && (!out_valid || out_ready);
    chk(in_ready == exp_rdy, freeze ? "R8" : "R1", "in_ready", in_ready, exp_rdy);
    if (prev_hold)
      chk(out_valid && out_i == prev_oi && out_q == prev_oq, "R1", "held beat",
          {out_valid, out_i, out_q}, {1'b1, prev_oi, prev_oq});
    prev_hold = out_valid && !out_ready;
    prev_oi = out_i;
    prev_oq = out_q;
    if (in_valid && in_ready) begin
      it.i = $signed(in_i); it.q = $signed(in_q); it.t = int'(m_ph[31:20]);
      it.acc_cyc = cyc; it.mark = stall_cnt;
      fifo.push_back(it);
    end
    if (out_valid && out_ready) begin
      if (fifo.size() == 0) begin
        chk(1'b0, "R1", "spurious beat", 1, 0);
      end else begin
        it = fifo.pop_front();
        c = wave(it.t + 1024);
        s = wave(it.t);
        ei = rsat(it.i * c + it.q * s);
        eq = rsat(it.q * c - it.i * s);
        chk($signed(out_i) == ei, "R3/R4", "out_i", $signed(out_i), ei);
        chk($signed(out_q) == eq, "R3/R4", "out_q", $signed(out_q), eq);
        lat = cyc - it.acc_cyc;
        if (it.mark == stall_cnt) chk(lat == 4, "R2", "latency", lat, 4);
        else                      chk(lat >= 4, "R2", "stalled latency", lat, 4);
        if (!freeze) begin
          adr = ((ei >>> 6) & 63) * 64 + ((eq >>> 6) & 63);
          e = lut_ref[adr];
          m_integ = m_integ + term(e, ki_shift);
          m_ph = m_ph + freq_word + m_integ + term(e, kp_shift);
        end
      end
    end
    if (!out_ready) stall_cnt++;
  endtask

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && !done) monitor_step();
  end

  task automatic send(int i, int q);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 12'(i);
    in_q = 12'(q);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      lut_wr_en = 1'b0;
    end
  endtask

  task automatic random_run(int n, int pv, int pr, bit stray_wr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = ($urandom % 100) < pv;
      in_i = 12'($urandom);
      in_q = 12'($urandom);
      out_ready = ($urandom % 100) < pr;
      lut_wr_en = stray_wr && (($urandom % 6) == 0);  // R8: ignored, not frozen
      lut_wr_addr = 12'($urandom);
      lut_wr_data = 1'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0;
    lut_wr_en = 1'b0;
  endtask

  task automatic fill_table();
    @(negedge clk);
    freeze = 1'b1;
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      lut_wr_en = 1'b1;
      lut_wr_addr = 12'(a);
      lut_wr_data = 1'($urandom);
      lut_ref[a] = lut_wr_data;
    end
    @(negedge clk);
    lut_wr_en = 1'b0;
    freeze = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_P * 2);
    // R9: state while reset is held
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    chk(phase == 32'd0, "R9", "phase in reset", phase, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

    fill_table();   // R8: writes under freeze, in_ready watched by monitor

    // R2/R3: single sample at angle zero, gains disabled
    freq_word = 32'd0; kp_shift = 6'd63; ki_shift = 6'd40; out_ready = 1'b1;
    send(1000, -500);
    idle(8);

    // R4: full-scale inputs while the angle steps by 45 degrees
    freq_word = 32'h2000_0000;
    send(2047, 2047);  send(-2048, -2048); send(2047, -2048); send(-2048, 2047);
    send(2047, 2047);  send(-2048, -2048); send(1024, 1024);  send(-1, 1);
    idle(10);

    // R6: small gains with a fixed offset, no back-pressure
    freq_word = 32'h0123_4567; kp_shift = 6'd20; ki_shift = 6'd12;
    random_run(600, 80, 100, 1'b0);
    idle(8);

    // R1/R7/R8: back-pressure plus stray writes while running
    kp_shift = 6'd24; ki_shift = 6'd16; freq_word = 32'hFFFF_F000;
    random_run(2500, 70, 60, 1'b1);

    // R7/R8: freeze in the middle of traffic, rewrite part of the table
    random_run(20, 90, 50, 1'b0);
    @(negedge clk);
    freeze = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      out_ready = ($urandom % 2) == 0;
      lut_wr_en = 1'b1;
      lut_wr_addr = 12'($urandom);
      lut_wr_data = 1'($urandom);
      lut_ref[lut_wr_addr] = lut_wr_data;
    end
    @(negedge clk);
    lut_wr_en = 1'b0;
    freeze = 1'b0;

    // R6: zero shifts and gains at the 32 boundary, wrapping offset
    kp_shift = 6'd0; ki_shift = 6'd32; freq_word = 32'h8000_0001;
    random_run(800, 60, 80, 1'b1);
    kp_shift = 6'd31; ki_shift = 6'd30;
    random_run(800, 60, 80, 1'b1);
    out_ready = 1'b1;
    idle(12);

    chk(fifo.size() == 0, "R1", "beats outstanding", fifo.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    done = 1'b1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule